// File: doc/BRIEF.md
# Debug Unit Control and Comparator Register Bank

This block is the byte-wide register file of an on-chip debug unit. It holds one control register and one bank of eight configuration bytes for each address comparator. Software reaches every comparator bank through a single shared eight-byte window. A selection field in the control register decides which comparator's bytes appear in that window.

Setting the arm bit freezes the configuration. While the unit is armed, only the arm bit, the bank selection and the trigger request can be written. Every other control bit and every comparator byte ignores writes. The trigger request stores no state. Writing it produces a single-cycle pulse, and it always reads back as zero.

The decoded control state and each comparator's 16-bit address mask are driven as outputs, for use by the matching and breakpoint logic elsewhere in the debug unit. Reads are combinational from the current register state. Writes take effect at the rising clock edge on which `bus_we` is sampled high.

Top module: `dbg_regbank`

## Requirements
- R1: After reset every control bit, every comparator byte, every mask output and the trigger pulse are zero.
- R2: The control register at offset 0x20 reads as follows: bit 7 is arm, bit 4 is halt mode, bit 3 is break enable, and bits 1:0 are bank select. Bits 6, 5 and 2 always read zero.
- R3: A write to 0x20 loads the arm bit (wdata[7]) and the bank select (wdata[1:0]) whether or not the unit is armed.
- R4: A write to 0x20 with wdata[6] set raises `dbg_trig_pulse` for exactly the one cycle after the write edge. No other write raises it, and the bit is never stored.
- R5: Halt mode (wdata[4]) and break enable (wdata[3]) load only if the arm bit was clear before the write. A write that clears the arm bit leaves them unchanged, so a second write is needed to change them.
- R6: With bank select 0, 1 or 2, offsets 0x28 to 0x2F read and write bytes 0 to 7 of comparator A, B or C respectively, provided the unit is not armed.
- R7: While armed, writes to the comparator window change no comparator byte.
- R8: With bank select 3, the window reads zero and writes to it change no comparator byte.
- R9: `cmp_mask` slice k (bits 16k+15:16k) equals {byte 6, byte 7} of comparator k. Byte 6 (offset 0x2E) is the high mask byte and byte 7 (offset 0x2F) is the low mask byte.
- R10: Reads of any offset other than 0x20 and 0x28 to 0x2F return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| dbg_armed | output | 1 | Arm bit |
| dbg_trig_pulse | output | 1 | One-cycle trigger request |
| dbg_halt_mode | output | 1 | Halt-mode control bit |
| dbg_brk_en | output | 1 | Break-enable control bit |
| dbg_bank_sel | output | 2 | Comparator bank select |
| cmp_mask | output | 48 | Concatenated 16-bit masks, comparator A in the low slice |

## Verification
The random sequence mixes control writes with the arm bit set about half the time, window writes under every bank selection, and writes to unmapped offsets. This separates a lock that reads the arm value before the write from one that reads it after, and it exposes a bank decoder that writes the wrong comparator or writes while locked. Directed cases add the following:
- a 0xFF control write, which exposes stored or leaking unimplemented bits;
- a disarming write followed by a clearing write, which shows the two-write rule;
- bank select 3, which confirms that the blank bank neither reads nor writes.

// File: rtl/dbg_regbank_pkg.sv
// Package: shared offsets, bit positions and the decoded control type
// for the debug register bank.
package dbg_regbank_pkg;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned SEL_W     = 2;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h20;
    localparam logic [ADDR_W-1:0] WIN_BASE = 8'h28;
    localparam int unsigned WIN_BYTES = 8;
    localparam int unsigned ARM_BIT   = 7;
    localparam int unsigned TRIG_BIT  = 6;
    localparam int unsigned HALT_BIT  = 4;
    localparam int unsigned BRK_BIT   = 3;
    localparam int unsigned MASK_HI_B = 6;
    localparam int unsigned MASK_LO_B = 7;

    typedef struct packed {
        logic             armed;
        logic             halt;
        logic             brk;
        logic [SEL_W-1:0] sel;
    } dbg_ctrl_t;
endpackage

// File: rtl/dbg_ctrl_reg.sv
// Control register of the debug unit.
// Assumes: wr_en is already qualified by the address decode of the control offset.
// The arm bit and the bank select always load. The halt and break bits load only
// when the arm bit was clear before the write. The trigger request is turned into
// a registered one-cycle pulse and is never stored.
module dbg_ctrl_reg
    import dbg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output dbg_ctrl_t         ctrl_o,
    output logic              trig_o,
    output logic [DATA_W-1:0] rdata_o
);
    dbg_ctrl_t ctrl_q;
    logic      trig_q;

    // Update the control fields; halt and break are gated by the arm bit held before the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.armed <= wdata[ARM_BIT];
            ctrl_q.sel   <= wdata[SEL_W-1:0];
            if (!ctrl_q.armed) begin
                ctrl_q.halt <= wdata[HALT_BIT];
                ctrl_q.brk  <= wdata[BRK_BIT];
            end
        end
    end

    // Generate the one-cycle trigger pulse from a write with the trigger bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= wr_en & wdata[TRIG_BIT];
    end

    // Assemble the read image; unimplemented bits and the trigger bit read as zero.
    always_comb begin
        rdata_o                = '0;
        rdata_o[ARM_BIT]       = ctrl_q.armed;
        rdata_o[HALT_BIT]      = ctrl_q.halt;
        rdata_o[BRK_BIT]       = ctrl_q.brk;
        rdata_o[SEL_W-1:0]     = ctrl_q.sel;
    end

    assign ctrl_o = ctrl_q;
    assign trig_o = trig_q;

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.armed |=> ($stable(ctrl_q.halt) && $stable(ctrl_q.brk)));
    // R3
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q.armed == $past(wdata[ARM_BIT]) && ctrl_q.sel == $past(wdata[SEL_W-1:0])));
    // R4
    trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(wr_en && wdata[TRIG_BIT]));
endmodule

// File: rtl/dbg_cmp_bank.sv
// One comparator's configuration bank: WIN_BYTES bytes of storage.
// Assumes: wr_en is qualified by the window decode and by bank selection; the bank
// gates its own writes with 'locked' (the arm bit). Bytes MASK_HI_B and MASK_LO_B
// form the 16-bit address mask output.
module dbg_cmp_bank
    import dbg_regbank_pkg::*;
#(
    parameter int unsigned NBYTES = WIN_BYTES,
    localparam int unsigned OFS_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              locked,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [15:0]       mask_o
);
    logic [DATA_W-1:0] store_q [NBYTES];
    logic              wr_ok;

    assign wr_ok = wr_en & ~locked;

    // Per-byte storage, each byte with its own write decode.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Load byte b when the window write hits it and the bank is unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n)                                store_q[b] <= '0;
            else if (wr_ok && ofs == OFS_W'(b))        store_q[b] <= wdata;
        end
    end

    // Read the addressed byte and form the mask output.
    always_comb begin
        rdata  = store_q[ofs];
        mask_o = {store_q[MASK_HI_B], store_q[MASK_LO_B]};
    end

    // R7
    locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mask_o) && $stable(store_q[0]) && $stable(store_q[1]));
endmodule

// File: rtl/dbg_read_mux.sv
// Read-data selector for the register bank.
// Assumes: at most one of hit_ctrl and hit_win is set. A bank select beyond the
// implemented comparators returns zero, and so do unmapped offsets.
module dbg_read_mux
    import dbg_regbank_pkg::*;
#(
    parameter int unsigned NUM_CMP = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hit_ctrl,
    input  logic                      hit_win,
    input  logic [SEL_W-1:0]          sel,
    input  logic [DATA_W-1:0]         ctrl_rdata,
    input  logic [NUM_CMP*DATA_W-1:0] bank_rdata,
    output logic [DATA_W-1:0]         rdata
);
    logic [DATA_W-1:0] win_data;

    // Pick the selected bank's byte; an unimplemented selection yields zero.
    always_comb begin
        win_data = '0;
        for (int k = 0; k < NUM_CMP; k++) begin
            if (sel == SEL_W'(k)) win_data = bank_rdata[k*DATA_W +: DATA_W];
        end
    end

    // Route the control image or the window byte; everything else reads zero.
    always_comb begin
        if (hit_ctrl)     rdata = ctrl_rdata;
        else if (hit_win) rdata = win_data;
        else              rdata = '0;
    end

    // R8
    blank_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_win && sel >= SEL_W'(NUM_CMP)) |-> rdata == '0);
endmodule

// File: rtl/dbg_regbank.sv
// Top of the debug register bank: decodes the byte bus onto the control
// register and the shared comparator window, and exposes the decoded state.
// Assumes: a single-cycle write strobe and combinational reads. NUM_CMP must
// fit below 2**SEL_W so that at least one selection shows a blank bank.
module dbg_regbank
    import dbg_regbank_pkg::*;
#(
    parameter int unsigned NUM_CMP = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  dbg_armed,
    output logic                  dbg_trig_pulse,
    output logic                  dbg_halt_mode,
    output logic                  dbg_brk_en,
    output logic [SEL_W-1:0]      dbg_bank_sel,
    output logic [NUM_CMP*16-1:0] cmp_mask
);
    localparam int unsigned OFS_W = $clog2(WIN_BYTES);

    logic                      hit_ctrl, hit_win;
    logic [OFS_W-1:0]          win_ofs;
    dbg_ctrl_t                 ctrl;
    logic [DATA_W-1:0]         ctrl_rdata;
    logic [NUM_CMP*DATA_W-1:0] bank_rdata;

    // Decode the offset into the control register and the comparator window.
    always_comb begin
        hit_ctrl = (bus_addr == CTRL_OFS);
        hit_win  = (bus_addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
        win_ofs  = bus_addr[OFS_W-1:0];
    end

    dbg_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we & hit_ctrl),
        .wdata   (bus_wdata),
        .ctrl_o  (ctrl),
        .trig_o  (dbg_trig_pulse),
        .rdata_o (ctrl_rdata)
    );

    // One bank per comparator, each written only when it is the selected one.
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        dbg_cmp_bank #(.NBYTES(WIN_BYTES)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_we & hit_win & (ctrl.sel == SEL_W'(k))),
            .locked (ctrl.armed),
            .ofs    (win_ofs),
            .wdata  (bus_wdata),
            .rdata  (bank_rdata[k*DATA_W +: DATA_W]),
            .mask_o (cmp_mask[k*16 +: 16])
        );
    end

    dbg_read_mux #(.NUM_CMP(NUM_CMP)) u_rmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_ctrl   (hit_ctrl),
        .hit_win    (hit_win),
        .sel        (ctrl.sel),
        .ctrl_rdata (ctrl_rdata),
        .bank_rdata (bank_rdata),
        .rdata      (bus_rdata)
    );

    assign dbg_armed     = ctrl.armed;
    assign dbg_halt_mode = ctrl.halt;
    assign dbg_brk_en    = ctrl.brk;
    assign dbg_bank_sel  = ctrl.sel;

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_ctrl || hit_win) |-> bus_rdata == '0);
    // R2
    ctrl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |-> (bus_rdata[6] == 1'b0 && bus_rdata[5] == 1'b0 && bus_rdata[2] == 1'b0));
    // R9
    mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_armed |=> $stable(cmp_mask));
endmodule

// File: tb/test_dbg_regbank.sv
module test_dbg_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int NCMP       = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        dbg_armed, dbg_trig_pulse, dbg_halt_mode, dbg_brk_en;
    logic [1:0]  dbg_bank_sel;
    logic [NCMP*16-1:0] cmp_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    bit       m_arm, m_halt, m_brk;
    bit [1:0] m_sel;
    bit [7:0] m_bank [NCMP][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_regbank #(.NUM_CMP(NCMP)) i_dbg_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_armed(dbg_armed),
        .dbg_trig_pulse(dbg_trig_pulse), .dbg_halt_mode(dbg_halt_mode),
        .dbg_brk_en(dbg_brk_en), .dbg_bank_sel(dbg_bank_sel), .cmp_mask(cmp_mask)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit in_win(logic [7:0] a);
        return a[7:3] == 5'b00101;
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        if (a == 8'h20) return {m_arm, 2'b00, m_halt, m_brk, 1'b0, m_sel};
        if (in_win(a) && m_sel < NCMP) return m_bank[m_sel][a[2:0]];
        return 8'h00;
    endfunction

    function automatic logic [NCMP*16-1:0] exp_mask();
        logic [NCMP*16-1:0] r;
        for (int k = 0; k < NCMP; k++) r[k*16 +: 16] = {m_bank[k][6], m_bank[k][7]};
        return r;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a == 8'h20) return "R2";
        if (in_win(a)) return (m_sel == 2'd3) ? "R8" : (m_arm ? "R7" : "R6");
        return "R10";
    endfunction

    // Write one byte, update the model, check the trigger pulse and state outputs.
    task automatic wr(logic [7:0] a, logic [7:0] d);
        bit exp_trig;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        exp_trig = (a == 8'h20) && d[6];
        if (a == 8'h20) begin
            if (!m_arm) begin m_halt = d[4]; m_brk = d[3]; end
            m_arm = d[7]; m_sel = d[1:0];
        end else if (in_win(a) && !m_arm && m_sel < NCMP) begin
            m_bank[m_sel][a[2:0]] = d;
        end
        chk("R4 trig pulse", dbg_trig_pulse, exp_trig);
        chk("R3/R5 ctrl outputs", {dbg_armed, dbg_halt_mode, dbg_brk_en, dbg_bank_sel},
            {m_arm, m_halt, m_brk, m_sel});
        chk("R9 mask outputs", cmp_mask, exp_mask());
    endtask

    task automatic rd(logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(tag_of(a), bus_rdata, exp_read(a));
    endtask

    initial begin
        process::self().srandom(32'd1234);
        for (int k = 0; k < NCMP; k++) for (int b = 0; b < 8; b++) m_bank[k][b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 outputs", {dbg_armed, dbg_trig_pulse, dbg_halt_mode, dbg_brk_en, dbg_bank_sel}, 0);
        chk("R1 masks", cmp_mask, 0);
        rd(8'h20);
        for (int b = 0; b < 8; b++) rd(8'h28 + b[7:0]);
        // R2: all-ones write shows only implemented bits; arms the unit
        wr(8'h20, 8'hFF);
        rd(8'h20);
        chk("R2 ctrl image", bus_rdata, 8'h9B);
        // R5: disarming write leaves halt/break; second write clears them
        wr(8'h20, 8'h00);
        rd(8'h20);
        chk("R5 after disarm", bus_rdata, 8'h18);
        wr(8'h20, 8'h00);
        rd(8'h20);
        chk("R5 second write", bus_rdata, 8'h00);
        // R6/R9: fill each bank with distinct data
        for (int k = 0; k < NCMP; k++) begin
            wr(8'h20, k[7:0]);
            for (int b = 0; b < 8; b++) wr(8'h28 + b[7:0], 8'(k * 16 + b + 1));
        end
        for (int k = 0; k < NCMP; k++) begin
            wr(8'h20, k[7:0]);
            for (int b = 0; b < 8; b++) rd(8'h28 + b[7:0]);
        end
        chk("R9 mask of C", cmp_mask[47:32], 16'h2728);
        // R8: blank bank reads zero and ignores writes
        wr(8'h20, 8'h03);
        wr(8'h2E, 8'hAA);
        rd(8'h2E);
        chk("R8 blank read", bus_rdata, 8'h00);
        // R7: armed window write is ignored
        wr(8'h20, 8'h81);
        wr(8'h2F, 8'h55);
        wr(8'h20, 8'h01);
        rd(8'h2F);
        chk("R7 locked byte", bus_rdata, 8'h18);
        // R10: unmapped offsets read zero and writes change nothing
        wr(8'h21, 8'hFF);
        wr(8'h27, 8'hFF);
        wr(8'h30, 8'hFF);
        rd(8'h21); rd(8'h00); rd(8'h30); rd(8'hFF);
        rd(8'h20);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            int kind = $urandom_range(0, 9);
            logic [7:0] a;
            logic [7:0] d = 8'($urandom);
            if (kind < 3)      a = 8'h20;
            else if (kind < 8) a = 8'h28 + 8'($urandom_range(0, 7));
            else               a = 8'($urandom);
            wr(a, d);
            rd(($urandom_range(0, 1) == 0) ? 8'h20 : 8'h28 + 8'($urandom_range(0, 7)));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule